// File: doc/BRIEF.md
# Double-Buffered Serial Divider Programming Port

This block is the control side of an integer-N frequency synthesizer. A slow three-wire serial link (a serial clock, a data line and a load strobe), plus a select line that steers the data, loads two things: a 20-bit divider word and an 8-bit auxiliary control word. The divider word is shifted into a primary register and copied into a secondary register when the load strobe rises. A live bank-select input then chooses which of the two words drives the decoded reference divider, main divider, swallow count and prescaler enable. This lets software prepare one setting while the other is in use and switch between them at once.

The auxiliary word is shifted in while the select line is high. It is copied into a holding register when that line falls, so a partly shifted word never reaches the outputs. Its bits drive a power-down flag and a continuous counter-load flag, and they choose which divider-chain signal appears on a monitor output. All of these take effect only while an active-low enable input is held low. The serial pins are sampled by the system clock through a synchronizer of `SYNC_STAGES` flops, so every effect is visible within `SYNC_STAGES + 1` clock cycles of the pin edge.

Top module: `pll_prog_if`

## Requirements
- R1: After reset, ref_div, main_div, swallow and presc_en are all zero for both values of bank_pick, and pwr_down, cnt_load and mon_out are 0.
- R2: A rising edge of ser_clk while ctl_load and aux_sel are both low shifts ser_dat into bit 0 of the 20-bit primary register and moves the older bits one place up, so the first bit sent ends in bit 19.
- R3: A rising edge of ctl_load copies the primary register into the secondary register and leaves the primary register unchanged.
- R4: With bank_pick at 1 the decoded fields follow the primary register. With bank_pick at 0 they follow the secondary register. The choice takes effect combinationally.
- R5: The 20-bit word decodes as follows: bits 19:18 give ref_div[5:4], 17:16 give main_div[8:7], 15 gives presc_en, 14:8 give main_div[6:0], 7:4 give ref_div[3:0] and 3:0 give swallow.
- R6: A rising edge of ser_clk while aux_sel is high and ctl_load is low shifts ser_dat into the 8-bit auxiliary register (the first bit sent ends in bit 7) and leaves the primary register unchanged.
- R7: The auxiliary register reaches the holding register only on a falling edge of aux_sel. Before that edge the control outputs keep their old values.
- R8: The holding register bits are used as follows: bit 5 routes div_main_in, bit 4 is power-down, bit 3 is counter load, bit 2 routes mod_sel_in and bit 1 routes div_ref_in. Bits 7, 6 and 0 have no effect. All of them act only while aux_en_n is 0. With aux_en_n at 1, pwr_down, cnt_load and mon_out are 0.
- R9: mon_out takes div_main_in if bit 5 is set, otherwise mod_sel_in if bit 2 is set, otherwise div_ref_in if bit 1 is set, and is 0 when none of these bits is set.
- R10: While the effective power-down flag is 1, mon_out is 0.
- R11: Rising edges of ser_clk while ctl_load is high shift neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, first bit is most significant |
| ctl_load | input | 1 | Low enables shifting; rising edge copies primary to secondary |
| aux_sel | input | 1 | High steers shifting to the auxiliary register; falling edge captures it |
| aux_en_n | input | 1 | Active-low enable for the auxiliary control bits |
| bank_pick | input | 1 | 1 selects the primary word, 0 the secondary word |
| div_main_in | input | 1 | Main divider output for monitoring |
| mod_sel_in | input | 1 | Prescaler modulus select for monitoring |
| div_ref_in | input | 1 | Reference divider output for monitoring |
| ref_div | output | 6 | Decoded reference divider value |
| main_div | output | 9 | Decoded main divider value |
| swallow | output | 4 | Decoded swallow count |
| presc_en | output | 1 | Decoded prescaler enable bit |
| pwr_down | output | 1 | Effective power-down flag |
| cnt_load | output | 1 | Effective continuous counter-load flag |
| mon_out | output | 1 | Monitor output selected by the auxiliary bits |

## Verification
The load strobe's rising edge, which copies the divider word, and the select line's falling edge, which captures the auxiliary word, can land in the same system clock cycle. Each drives a separate register, and neither may block or corrupt the other. The bench shifts a fresh divider word and a fresh auxiliary word first. It then raises ctl_load and drops aux_sel in the same cycle. After the synchronizer delay it checks that the secondary bank shows the new divider word and that the control flags have moved to the new auxiliary value.

// File: rtl/pllif_pkg.sv
package pllif_pkg;
   // Positions inside the 8-bit auxiliary holding register (first bit shifted in = bit 7)
   localparam int AUX_W        = 8;
   localparam int AUX_FP_POS   = 5;
   localparam int AUX_PD_POS   = 4;
   localparam int AUX_LOAD_POS = 3;
   localparam int AUX_MSEL_POS = 2;
   localparam int AUX_FC_POS   = 1;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_MOD  = 2'd2,
      SRC_REF  = 2'd3
   } mon_src_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;
endpackage

// File: rtl/pllif_sync.sv
module pllif_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl = din;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            end else begin
               chain_q[0] <= din;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign lvl = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pllif_edge.sv
module pllif_edge
   import pllif_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign hit = lvl & ~prev_q;
      end else begin : g_fall
         assign hit = ~lvl & prev_q;
      end
   endgenerate
endmodule

// File: rtl/pllif_shift.sv
module pllif_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (step) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/pllif_word_decode.sv
module pllif_word_decode #(
   parameter int R_W = 6,
   parameter int M_W = 9,
   parameter int A_W = 4,
   localparam int PRI_W = R_W + M_W + A_W + 1
) (
   input  logic [PRI_W-1:0] word,
   output logic [R_W-1:0]   r_val,
   output logic [M_W-1:0]   m_val,
   output logic [A_W-1:0]   a_val,
   output logic             pre_val
);
   // Two upper R bits, two upper M bits and the prescaler bit sit at the top;
   // the remaining M bits, remaining R bits and the A field follow downward.
   localparam int P_RHI   = PRI_W - 1;
   localparam int P_MHI   = PRI_W - 3;
   localparam int P_PRE   = PRI_W - 5;
   localparam int P_MLO   = P_PRE - 1;
   localparam int P_RLO   = A_W + R_W - 3;

   assign r_val   = {word[P_RHI -: 2], word[P_RLO -: (R_W-2)]};
   assign m_val   = {word[P_MHI -: 2], word[P_MLO -: (M_W-2)]};
   assign pre_val = word[P_PRE];
   assign a_val   = word[A_W-1:0];
endmodule

// File: rtl/pllif_mon_mux.sv
module pllif_mon_mux
   import pllif_pkg::*;
(
   input  logic sel_main,
   input  logic sel_mod,
   input  logic sel_ref,
   input  logic pd,
   input  logic main_in,
   input  logic mod_in,
   input  logic ref_in,
   output logic mon
);
   mon_src_e src;

   always_comb begin
      if (pd)            src = SRC_NONE;
      else if (sel_main) src = SRC_MAIN;
      else if (sel_mod)  src = SRC_MOD;
      else if (sel_ref)  src = SRC_REF;
      else               src = SRC_NONE;
   end

   always_comb begin
      unique case (src)
         SRC_MAIN: mon = main_in;
         SRC_MOD:  mon = mod_in;
         SRC_REF:  mon = ref_in;
         default:  mon = 1'b0;
      endcase
   end
endmodule

// File: rtl/pll_prog_if.sv
module pll_prog_if
   import pllif_pkg::*;
#(
   parameter int R_W         = 6,
   parameter int M_W         = 9,
   parameter int A_W         = 4,
   parameter int ENH_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int PRI_W = R_W + M_W + A_W + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           ctl_load,
   input  logic           aux_sel,
   input  logic           aux_en_n,
   input  logic           bank_pick,
   input  logic           div_main_in,
   input  logic           mod_sel_in,
   input  logic           div_ref_in,
   output logic [R_W-1:0] ref_div,
   output logic [M_W-1:0] main_div,
   output logic [A_W-1:0] swallow,
   output logic           presc_en,
   output logic           pwr_down,
   output logic           cnt_load
   ,output logic          mon_out
);
   // Elaboration-time parameter checks
   generate
      if (R_W < 3 || M_W < 3 || A_W < 1) begin : g_bad_fields
         $error("pll_prog_if: R_W and M_W must be at least 3, A_W at least 1");
      end
      if (ENH_W != AUX_W) begin : g_bad_aux
         $error("pll_prog_if: ENH_W must equal the fixed auxiliary layout width");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("pll_prog_if: SYNC_STAGES must not be negative");
      end
   endgenerate

   // Pin synchronizer: {ser_clk, ser_dat, ctl_load, aux_sel}
   logic [3:0] pins_lvl;
   logic       sclk_lvl, dat_lvl, load_lvl, aux_lvl;
   logic       sclk_rise, load_rise, aux_fall;

   pllif_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ser_clk, ser_dat, ctl_load, aux_sel}),
      .lvl   (pins_lvl)
   );

   assign {sclk_lvl, dat_lvl, load_lvl, aux_lvl} = pins_lvl;

   pllif_edge #(.KIND(EDGE_RISE)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .lvl(sclk_lvl), .hit(sclk_rise));
   pllif_edge #(.KIND(EDGE_RISE)) u_load_edge (
      .clk(clk), .rst_n(rst_n), .lvl(load_lvl), .hit(load_rise));
   pllif_edge #(.KIND(EDGE_FALL)) u_aux_edge (
      .clk(clk), .rst_n(rst_n), .lvl(aux_lvl), .hit(aux_fall));

   // Shift steering
   logic pri_step, aux_step;
   assign pri_step = sclk_rise & ~load_lvl & ~aux_lvl;
   assign aux_step = sclk_rise & ~load_lvl &  aux_lvl;

   logic [PRI_W-1:0] pri_q;
   logic [PRI_W-1:0] sec_q;
   logic [ENH_W-1:0] aux_sr_q;
   logic [ENH_W-1:0] enh_buf_q;

   pllif_shift #(.W(PRI_W)) u_pri_sr (
      .clk(clk), .rst_n(rst_n), .step(pri_step), .din(dat_lvl), .q(pri_q));
   pllif_shift #(.W(ENH_W)) u_aux_sr (
      .clk(clk), .rst_n(rst_n), .step(aux_step), .din(dat_lvl), .q(aux_sr_q));

   // Secondary bank and auxiliary holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sec_q <= '0;
      else if (load_rise) sec_q <= pri_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        enh_buf_q <= '0;
      else if (aux_fall) enh_buf_q <= aux_sr_q;
   end

   // Live bank selection and field decode
   logic [PRI_W-1:0] word_sel;
   assign word_sel = bank_pick ? pri_q : sec_q;

   pllif_word_decode #(.R_W(R_W), .M_W(M_W), .A_W(A_W)) u_decode (
      .word    (word_sel),
      .r_val   (ref_div),
      .m_val   (main_div),
      .a_val   (swallow),
      .pre_val (presc_en)
   );

   // Auxiliary controls gated by the active-low enable
   logic act_fp, act_pd, act_load, act_msel, act_fc;
   assign act_fp   = ~aux_en_n & enh_buf_q[AUX_FP_POS];
   assign act_pd   = ~aux_en_n & enh_buf_q[AUX_PD_POS];
   assign act_load = ~aux_en_n & enh_buf_q[AUX_LOAD_POS];
   assign act_msel = ~aux_en_n & enh_buf_q[AUX_MSEL_POS];
   assign act_fc   = ~aux_en_n & enh_buf_q[AUX_FC_POS];

   assign pwr_down = act_pd;
   assign cnt_load = act_load;

   pllif_mon_mux u_mon (
      .sel_main (act_fp),
      .sel_mod  (act_msel),
      .sel_ref  (act_fc),
      .pd       (act_pd),
      .main_in  (div_main_in),
      .mod_in   (mod_sel_in),
      .ref_in   (div_ref_in),
      .mon      (mon_out)
   );
endmodule

// File: rtl/pllif_chk.sv
module pllif_chk #(
   parameter int PRI_W = 20,
   parameter int ENH_W = 8,
   parameter int A_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_rise,
   input logic             load_rise,
   input logic             load_lvl,
   input logic             aux_fall,
   input logic [PRI_W-1:0] pri,
   input logic [PRI_W-1:0] sec,
   input logic [ENH_W-1:0] enh_buf,
   input logic             bank_pick,
   input logic             aux_en_n,
   input logic             pwr_down,
   input logic             cnt_load,
   input logic             mon_out,
   input logic [A_W-1:0]   swallow
);
   // R3: a load edge leaves the primary word in the secondary bank
   a_r3_copy: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise |=> (sec == $past(pri)));

   // R11: serial clock edges during a high load strobe do not shift
   a_r11_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_rise && load_lvl) |=> $stable(pri));

   // R7: holding register moves only after a select falling edge
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_fall |=> $stable(enh_buf));

   // R8: disabled auxiliary bits force all controls low
   a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
      aux_en_n |-> (!pwr_down && !cnt_load && !mon_out));

   // R4: primary bank drives the swallow field when picked
   a_r4_bank: assert property (@(posedge clk) disable iff (!rst_n)
      bank_pick |-> (swallow == pri[A_W-1:0]));

   // R10: power-down silences the monitor output
   a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !mon_out);
endmodule

bind pll_prog_if pllif_chk #(.PRI_W(PRI_W), .ENH_W(ENH_W), .A_W(A_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_rise  (sclk_rise),
   .load_rise (load_rise),
   .load_lvl  (load_lvl),
   .aux_fall  (aux_fall),
   .pri       (pri_q),
   .sec       (sec_q),
   .enh_buf   (enh_buf_q),
   .bank_pick (bank_pick),
   .aux_en_n  (aux_en_n),
   .pwr_down  (pwr_down),
   .cnt_load  (cnt_load),
   .mon_out   (mon_out),
   .swallow   (swallow)
);

// File: tb/pll_prog_if_test.sv
module pll_prog_if_test;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam int NVEC       = 4;
   localparam logic [19:0] VEC [NVEC] = '{20'hA5C3E, 20'h5A1C1, 20'hFFFFF, 20'h80001};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ser_clk, ser_dat, ctl_load, aux_sel, aux_en_n, bank_pick;
   logic       div_main_in, mod_sel_in, div_ref_in;
   logic [5:0] ref_div;
   logic [8:0] main_div;
   logic [3:0] swallow;
   logic       presc_en, pwr_down, cnt_load, mon_out;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_prog_if uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ctl_load(ctl_load), .aux_sel(aux_sel), .aux_en_n(aux_en_n),
      .bank_pick(bank_pick), .div_main_in(div_main_in), .mod_sel_in(mod_sel_in),
      .div_ref_in(div_ref_in), .ref_div(ref_div), .main_div(main_div),
      .swallow(swallow), .presc_en(presc_en), .pwr_down(pwr_down),
      .cnt_load(cnt_load), .mon_out(mon_out));

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected field split from the R5 layout
   task automatic check_word(string tag, logic [19:0] w);
      #1;
      check({tag, " ref_div"},  32'(ref_div),  32'({w[19:18], w[7:4]}));
      check({tag, " main_div"}, 32'(main_div), 32'({w[17:16], w[14:8]}));
      check({tag, " presc_en"}, 32'(presc_en), 32'(w[15]));
      check({tag, " swallow"},  32'(swallow),  32'(w[3:0]));
   endtask

   task automatic shift_bits(logic [31:0] d, int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = d[i];
         ser_clk = 1'b0;
         wait_cyc(SETTLE);
         ser_clk = 1'b1;
         wait_cyc(SETTLE);
      end
      ser_clk = 1'b0;
      wait_cyc(SETTLE);
   endtask

   task automatic pulse_load();
      ctl_load = 1'b1;
      wait_cyc(SETTLE);
      ctl_load = 1'b0;
      wait_cyc(SETTLE);
   endtask

   task automatic load_aux(logic [7:0] v);
      aux_sel = 1'b1;
      wait_cyc(SETTLE);
      shift_bits(32'(v), 8);
      aux_sel = 1'b0;
      wait_cyc(SETTLE);
   endtask

   task automatic mon_case(string tag, logic fp, logic ms, logic fc, logic exp);
      div_main_in = fp;
      mod_sel_in  = ms;
      div_ref_in  = fc;
      #1;
      check(tag, 32'(mon_out), 32'(exp));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [19:0] prev;
      rst_n = 1'b0;
      ser_clk = 0; ser_dat = 0; ctl_load = 0; aux_sel = 0; aux_en_n = 0;
      bank_pick = 1; div_main_in = 1; mod_sel_in = 1; div_ref_in = 1;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1: reset state on both banks and controls
      check_word("R1 bank1", 20'h0);
      bank_pick = 0;
      check_word("R1 bank0", 20'h0);
      check("R1 pwr_down", 32'(pwr_down), 0);
      check("R1 cnt_load", 32'(cnt_load), 0);
      check("R1 mon_out",  32'(mon_out),  0);

      // R2 R3 R4 R5: vector table walk
      prev = '0;
      for (int i = 0; i < NVEC; i++) begin
         shift_bits(32'(VEC[i]), 20);
         bank_pick = 1;
         check_word("R2 primary after shift", VEC[i]);
         bank_pick = 0;
         check_word("R4 secondary keeps old", prev);
         pulse_load();
         check_word("R3 secondary after load", VEC[i]);
         bank_pick = 1;
         check_word("R3 primary unchanged", VEC[i]);
         prev = VEC[i];
      end

      // R11: shifting while load strobe is high
      ctl_load = 1'b1;
      wait_cyc(SETTLE);
      shift_bits(32'h1F, 5);
      ctl_load = 1'b0;
      wait_cyc(SETTLE);
      check_word("R11 no shift under load", 20'h80001);

      // R6 R7: auxiliary shift, capture only on falling select
      aux_sel = 1'b1;
      wait_cyc(SETTLE);
      shift_bits(32'h20, 8);
      check_word("R6 primary untouched", 20'h80001);
      mon_case("R7 before capture", 1, 1, 1, 0);
      aux_sel = 1'b0;
      wait_cyc(SETTLE);
      mon_case("R8 fp route high", 1, 0, 0, 1);
      mon_case("R8 fp route low",  0, 1, 1, 0);
      aux_en_n = 1'b1;
      mon_case("R8 disabled", 1, 1, 1, 0);
      aux_en_n = 1'b0;

      // R9: priority order
      load_aux(8'b0010_0110);
      mon_case("R9 fp over msel", 0, 1, 1, 0);
      mon_case("R9 fp wins",      1, 0, 0, 1);
      load_aux(8'b0000_0110);
      mon_case("R9 msel over fc", 1, 0, 1, 0);
      mon_case("R9 msel wins",    0, 1, 0, 1);
      load_aux(8'b0000_0010);
      mon_case("R9 fc low",  1, 1, 0, 0);
      mon_case("R9 fc high", 0, 0, 1, 1);
      load_aux(8'b0000_0000);
      mon_case("R9 none selected", 1, 1, 1, 0);

      // R8: reserved bits ignored
      load_aux(8'b1100_0001);
      mon_case("R8 reserved mon", 1, 1, 1, 0);
      check("R8 reserved pwr_down", 32'(pwr_down), 0);
      check("R8 reserved cnt_load", 32'(cnt_load), 0);

      // R10: power-down silences monitor
      load_aux(8'b0011_1000);
      check("R10 pwr_down set", 32'(pwr_down), 1);
      check("R8 cnt_load set",  32'(cnt_load), 1);
      mon_case("R10 mon quiet", 1, 1, 1, 0);
      aux_en_n = 1'b1;
      #1;
      check("R8 gated pwr_down", 32'(pwr_down), 0);
      check("R8 gated cnt_load", 32'(cnt_load), 0);
      aux_en_n = 1'b0;

      // Same-cycle load copy and auxiliary capture
      shift_bits(32'h3C5A7, 20);
      aux_sel = 1'b1;
      wait_cyc(SETTLE);
      shift_bits(32'h08, 8);
      ctl_load = 1'b1;
      aux_sel  = 1'b0;
      wait_cyc(SETTLE);
      bank_pick = 0;
      check_word("R3 copy with capture", 20'h3C5A7);
      check("R7 capture with copy load", 32'(cnt_load), 1);
      check("R7 capture with copy pd",   32'(pwr_down), 0);
      ctl_load = 1'b0;
      wait_cyc(SETTLE);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule